// File: doc/BRIEF.md
# Ping-Pong OUT Endpoint Receive Buffer

This block sits between the serial engine of a USB device and the processor that consumes OUT data on one endpoint. The serial engine hands over packet bytes one strobe at a time. It closes each packet with an end-of-packet strobe, or throws it away with an abort strobe. The block keeps two packet slots, each `SLOT_BYTES` deep; with the default setting the two slots make 256 bytes in total. Bytes always go into the slot selected for filling. A committed packet raises a sticky interrupt, and the fill side then moves to the other slot.

The processor drains the oldest complete packet. Each read strobe consumes one byte, and the byte is visible in the low eight bits of a 32-bit data word. A count output tells software how many reads remain in the current packet. If both slots hold complete packets, there is nowhere to put a new packet, so the block asks the serial engine to answer NAK. That request persists until the final byte of the oldest packet has been read and its whole slot is free again.

Top module: `oep_pingpong_rx`

## Requirements
- R1: After reset, `nak_req`, `irq`, `rd_avail`, `rd_data` and `rd_count` are all zero.
- R2: Each cycle with `rx_byte_vld` high stores `rx_byte` in the fill slot. An `rx_eop` strobe commits the packet. A byte that arrives in the same cycle as `rx_eop` is the packet's last byte. After the commit, `rd_avail` is high and `rd_count` equals the packet length.
- R3: While `rd_avail` is high, `rd_data[7:0]` is the next unread byte, in arrival order, and `rd_data[31:8]` is zero. `rd_count` is the number of bytes not yet read. Each `rd_stb` advances by one byte. While `rd_avail` is low, `rd_data` and `rd_count` are zero.
- R4: Reading the final byte of a packet frees its slot. Draining then moves to the other slot, so packets come out in the order they were committed.
- R5: `nak_req` is high exactly when both slots hold complete packets. Bytes and end-of-packet strobes that arrive while `nak_req` is high are ignored.
- R6: `nak_req` stays high while the oldest packet is only partly read. It falls in the cycle after that packet's final byte is read.
- R7: `irq` goes high the cycle after a commit. It stays high until `irq_clr` is pulsed. A commit in the same cycle as `irq_clr` leaves `irq` high.
- R8: `rx_abort` discards the bytes received so far and does not raise `irq`. If `rx_abort` and `rx_eop` arrive in the same cycle, the abort wins. The next packet starts at byte zero of the same slot.
- R9: An end-of-packet strobe with no bytes received commits nothing and does not raise `irq`.
- R10: Bytes beyond `SLOT_BYTES` in one packet are dropped. The packet commits with a length of `SLOT_BYTES`, and it holds the first `SLOT_BYTES` bytes.
- R11: `rd_stb` while `rd_avail` is low has no effect on later reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_byte_vld | input | 1 | Byte strobe from the serial engine |
| rx_byte | input | DATA_W | Received byte |
| rx_eop | input | 1 | End-of-packet strobe |
| rx_abort | input | 1 | Error/abort strobe; drops the partial packet |
| irq_clr | input | 1 | Write-one-to-clear strobe for `irq` |
| rd_stb | input | 1 | Processor read strobe; consumes one byte |
| nak_req | output | 1 | Level asking the serial engine to NAK the next OUT |
| irq | output | 1 | Sticky packet-received interrupt |
| rd_avail | output | 1 | A complete packet is waiting to be drained |
| rd_data | output | RD_W | Read word; byte in bits 7:0, upper bits zero |
| rd_count | output | CNT_W | Bytes left to read in the head packet |

## Verification
Two pairs of events can fall in the same clock cycle. In the first, the final read of one slot coincides with the end-of-packet strobe for the other slot. In the second, an interrupt-clear strobe coincides with a fresh commit. The bench forces the first pair by receiving a second packet while the first is being drained, and placing its end-of-packet in the exact cycle of the last read. It then judges that the second packet becomes the head, with its full count, no NAK and the interrupt set. It forces the second pair by pulsing the clear together with an end-of-packet and expecting the flag to remain high. Around these cases, a sweep of every packet length up to the slot depth and beyond checks counts, byte order and the truncation point.

// File: rtl/oep_pkg.sv
package oep_pkg;

  typedef enum logic {SLOT_A = 1'b0, SLOT_B = 1'b1} slot_e;

  function automatic slot_e other_slot(slot_e s);
    return (s == SLOT_A) ? SLOT_B : SLOT_A;
  endfunction

  // position pos is the final byte of a packet holding total bytes
  function automatic logic last_byte(int unsigned pos, int unsigned total);
    return (pos + 1) == total;
  endfunction

  function automatic int unsigned bytes_left(int unsigned total, int unsigned pos);
    return (total > pos) ? total - pos : 0;
  endfunction

  function automatic logic room_left(int unsigned filled, int unsigned depth);
    return filled < depth;
  endfunction

endpackage

// File: rtl/oep_slot_store.sv
module oep_slot_store
  import oep_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SLOT_BYTES = 128,
  parameter int IDX_W      = 7,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  slot_e             wr_slot,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit_en,
  input  logic [CNT_W-1:0]  commit_cnt,
  input  logic              release_en,
  input  slot_e             rd_slot,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [1:0]        slot_full,
  output logic [DATA_W-1:0] rd_byte,
  output logic [CNT_W-1:0]  rd_cnt
);

  logic [DATA_W-1:0] byte_s [2];
  logic [CNT_W-1:0]  cnt_s  [2];

  for (genvar g = 0; g < 2; g++) begin : g_slot
    localparam slot_e MY_SLOT = (g == 0) ? SLOT_A : SLOT_B;

    logic [DATA_W-1:0] mem [SLOT_BYTES];
    logic [CNT_W-1:0]  cnt_q;
    logic              full_q;
    logic              wr_here;
    logic              rd_here;

    assign wr_here = (wr_slot == MY_SLOT);
    assign rd_here = (rd_slot == MY_SLOT);

    always_ff @(posedge clk) begin
      if (wr_en && wr_here) mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        cnt_q  <= '0;
      end else if (commit_en && wr_here) begin
        full_q <= 1'b1;
        cnt_q  <= commit_cnt;
      end else if (release_en && rd_here) begin
        full_q <= 1'b0;
        cnt_q  <= '0;
      end
    end

    assign byte_s[g]    = mem[rd_idx];
    assign cnt_s[g]     = cnt_q;
    assign slot_full[g] = full_q;
  end

  assign rd_byte = byte_s[rd_slot];
  assign rd_cnt  = cnt_s[rd_slot];

endmodule

// File: rtl/oep_fill_ctl.sv
module oep_fill_ctl
  import oep_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SLOT_BYTES = 128,
  parameter int IDX_W      = 7,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_byte_vld,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_eop,
  input  logic              rx_abort,
  input  logic [1:0]        slot_full,
  output logic              nak,
  output logic              wr_en,
  output slot_e             wr_slot,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              commit_en,
  output logic [CNT_W-1:0]  commit_cnt
);

  slot_e            fill_sel;
  logic [CNT_W-1:0] fill_cnt;

  assign nak     = slot_full[fill_sel];
  assign wr_slot = fill_sel;
  assign wr_idx  = fill_cnt[IDX_W-1:0];
  assign wr_data = rx_byte;

  assign wr_en      = rx_byte_vld && !nak && !rx_abort &&
                      room_left(32'(fill_cnt), SLOT_BYTES);
  assign commit_cnt = fill_cnt + CNT_W'(wr_en);
  assign commit_en  = rx_eop && !nak && !rx_abort && (commit_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_sel <= SLOT_A;
      fill_cnt <= '0;
    end else if (rx_abort) begin
      fill_cnt <= '0;
    end else if (commit_en) begin
      fill_cnt <= '0;
      fill_sel <= other_slot(fill_sel);
    end else if (wr_en) begin
      fill_cnt <= fill_cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/oep_drain_ctl.sv
module oep_drain_ctl
  import oep_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic [1:0]       slot_full,
  input  logic [CNT_W-1:0] head_cnt,
  output slot_e            drain_sel,
  output logic [IDX_W-1:0] rd_idx,
  output logic             avail,
  output logic             release_en,
  output logic [CNT_W-1:0] remaining
);

  logic [CNT_W-1:0] pos_q;
  logic             take;

  assign avail      = slot_full[drain_sel];
  assign take       = rd_stb && avail;
  assign release_en = take && last_byte(32'(pos_q), 32'(head_cnt));
  assign remaining  = CNT_W'(bytes_left(32'(head_cnt), 32'(pos_q)));
  assign rd_idx     = pos_q[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_sel <= SLOT_A;
      pos_q     <= '0;
    end else if (release_en) begin
      drain_sel <= other_slot(drain_sel);
      pos_q     <= '0;
    end else if (take) begin
      pos_q <= pos_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/oep_pingpong_rx.sv
module oep_pingpong_rx
  import oep_pkg::*;
#(
  parameter  int DATA_W     = 8,
  parameter  int SLOT_BYTES = 128,
  parameter  int RD_W       = 32,
  localparam int IDX_W      = $clog2(SLOT_BYTES),
  localparam int CNT_W      = $clog2(SLOT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_byte_vld,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_eop,
  input  logic              rx_abort,
  input  logic              irq_clr,
  input  logic              rd_stb,
  output logic              nak_req,
  output logic              irq,
  output logic              rd_avail,
  output logic [RD_W-1:0]   rd_data,
  output logic [CNT_W-1:0]  rd_count
);

  // named internal events, visible to the checker
  logic              commit_evt;
  logic              release_evt;

  logic              wr_en;
  slot_e             wr_slot;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic [CNT_W-1:0]  commit_cnt;
  logic [1:0]        slot_full;
  slot_e             drain_sel;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rd_byte;
  logic [CNT_W-1:0]  head_cnt;
  logic [CNT_W-1:0]  remaining;

  oep_fill_ctl #(
    .DATA_W(DATA_W), .SLOT_BYTES(SLOT_BYTES), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_fill (
    .clk(clk), .rst_n(rst_n),
    .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
    .rx_eop(rx_eop), .rx_abort(rx_abort),
    .slot_full(slot_full), .nak(nak_req),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx), .wr_data(wr_data),
    .commit_en(commit_evt), .commit_cnt(commit_cnt)
  );

  oep_slot_store #(
    .DATA_W(DATA_W), .SLOT_BYTES(SLOT_BYTES), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx), .wr_data(wr_data),
    .commit_en(commit_evt), .commit_cnt(commit_cnt),
    .release_en(release_evt), .rd_slot(drain_sel), .rd_idx(rd_idx),
    .slot_full(slot_full), .rd_byte(rd_byte), .rd_cnt(head_cnt)
  );

  oep_drain_ctl #(
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_drain (
    .clk(clk), .rst_n(rst_n),
    .rd_stb(rd_stb), .slot_full(slot_full), .head_cnt(head_cnt),
    .drain_sel(drain_sel), .rd_idx(rd_idx), .avail(rd_avail),
    .release_en(release_evt), .remaining(remaining)
  );

  // sticky interrupt; a new commit outranks the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq <= 1'b0;
    else if (commit_evt) irq <= 1'b1;
    else if (irq_clr)    irq <= 1'b0;
  end

  assign rd_data  = rd_avail ? RD_W'(rd_byte) : '0;
  assign rd_count = rd_avail ? remaining : '0;

endmodule

// File: rtl/oep_pingpong_rx_chk.sv
module oep_pingpong_rx_chk #(
  parameter int DATA_W = 8,
  parameter int RD_W   = 32,
  parameter int CNT_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_abort,
  input logic             irq_clr,
  input logic             rd_stb,
  input logic             nak_req,
  input logic             irq,
  input logic             rd_avail,
  input logic [RD_W-1:0]  rd_data,
  input logic [CNT_W-1:0] rd_count,
  input logic             commit_evt,
  input logic             release_evt
);

  AST_NAK_NEEDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    nak_req |-> rd_avail); // R5

  AST_NAK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    nak_req && !release_evt |=> nak_req); // R6

  AST_NAK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    nak_req && release_evt |=> !nak_req); // R6

  AST_IRQ_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> irq); // R7

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq); // R7

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort && !irq |=> !irq); // R8

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[RD_W-1:DATA_W] == '0); // R3

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_avail |-> (rd_data == '0 && rd_count == '0)); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_avail && rd_count > CNT_W'(1) |=>
      rd_count == $past(rd_count) - CNT_W'(1)); // R3

endmodule

bind oep_pingpong_rx oep_pingpong_rx_chk #(
  .DATA_W(DATA_W), .RD_W(RD_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_abort(rx_abort), .irq_clr(irq_clr),
  .rd_stb(rd_stb), .nak_req(nak_req), .irq(irq), .rd_avail(rd_avail),
  .rd_data(rd_data), .rd_count(rd_count),
  .commit_evt(commit_evt), .release_evt(release_evt)
);

// File: tb/test_oep_pingpong_rx.sv
module test_oep_pingpong_rx;

  localparam int DW = 8;
  localparam int SB = 8;
  localparam int RW = 32;
  localparam int CW = $clog2(SB + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_byte_vld = 1'b0;
  logic [DW-1:0] rx_byte = '0;
  logic          rx_eop = 1'b0;
  logic          rx_abort = 1'b0;
  logic          irq_clr = 1'b0;
  logic          rd_stb = 1'b0;
  logic          nak_req;
  logic          irq;
  logic          rd_avail;
  logic [RW-1:0] rd_data;
  logic [CW-1:0] rd_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  oep_pingpong_rx #(.DATA_W(DW), .SLOT_BYTES(SB), .RD_W(RW)) i_oep_pingpong_rx (
    .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
    .rx_eop(rx_eop), .rx_abort(rx_abort), .irq_clr(irq_clr), .rd_stb(rd_stb),
    .nak_req(nak_req), .irq(irq), .rd_avail(rd_avail),
    .rd_data(rd_data), .rd_count(rd_count)
  );

  function automatic logic [DW-1:0] pat(int seed, int i);
    return DW'(seed * 37 + i * 11 + 3);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bytes(int len, int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_byte_vld = 1'b1;
      rx_byte = pat(seed, i);
    end
    @(negedge clk);
    rx_byte_vld = 1'b0;
  endtask

  task automatic send_pkt(int len, int seed);
    send_bytes(len, seed);
    rx_eop = 1'b1;
    @(negedge clk);
    rx_eop = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  // R3 R4: read len bytes and compare each one and the remaining count
  task automatic drain_pkt(int len, int seed, string req);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      chk(rd_avail == 1'b1, req, int'(rd_avail), 1);
      chk(rd_count == CW'(len - i), req, int'(rd_count), len - i);
      chk(rd_data == RW'(pat(seed, i)), req, int'(rd_data), int'(pat(seed, i)));
      rd_stb = 1'b1;
    end
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(nak_req == 0, "R1", int'(nak_req), 0);
    chk(irq == 0, "R1", int'(irq), 0);
    chk(rd_avail == 0, "R1", int'(rd_avail), 0);
    chk(rd_data == 0, "R1", int'(rd_data), 0);
    chk(rd_count == 0, "R1", int'(rd_count), 0);

    // R11: reads with nothing available have no effect
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;

    // R2 R3 R4: sweep every packet length that fits
    for (int len = 1; len <= SB; len++) begin
      send_pkt(len, len);
      chk(rd_count == CW'(len), "R2", int'(rd_count), len);
      chk(irq == 1, "R7", int'(irq), 1);
      clear_irq();
      chk(irq == 0, "R7", int'(irq), 0);
      drain_pkt(len, len, (len == 1) ? "R11" : "R3");
      chk(rd_avail == 0, "R4", int'(rd_avail), 0);
    end

    // R10: overflow truncates at slot depth
    send_pkt(SB + 2, 40);
    chk(rd_count == CW'(SB), "R10", int'(rd_count), SB);
    drain_pkt(SB, 40, "R10");
    clear_irq();

    // R2: byte in the same cycle as end-of-packet is the last byte
    send_bytes(2, 41);
    rx_byte_vld = 1'b1; rx_byte = pat(41, 2); rx_eop = 1'b1;
    @(negedge clk);
    rx_byte_vld = 1'b0; rx_eop = 1'b0;
    chk(rd_count == CW'(3), "R2", int'(rd_count), 3);
    drain_pkt(3, 41, "R2");
    clear_irq();

    // R9: empty packet
    @(negedge clk); rx_eop = 1'b1;
    @(negedge clk); rx_eop = 1'b0;
    chk(irq == 0, "R9", int'(irq), 0);
    chk(rd_avail == 0, "R9", int'(rd_avail), 0);

    // R8: abort drops the partial packet
    send_bytes(3, 50);
    rx_abort = 1'b1;
    @(negedge clk); rx_abort = 1'b0;
    chk(irq == 0, "R8", int'(irq), 0);
    chk(rd_avail == 0, "R8", int'(rd_avail), 0);
    // R8: abort wins over a same-cycle end-of-packet
    send_bytes(2, 51);
    rx_abort = 1'b1; rx_eop = 1'b1;
    @(negedge clk); rx_abort = 1'b0; rx_eop = 1'b0;
    chk(irq == 0, "R8", int'(irq), 0);
    chk(rd_avail == 0, "R8", int'(rd_avail), 0);
    send_pkt(2, 52);
    drain_pkt(2, 52, "R8");
    clear_irq();

    // R5 R6: two full slots force NAK, third packet ignored
    send_pkt(3, 60);
    chk(nak_req == 0, "R5", int'(nak_req), 0);
    send_pkt(5, 61);
    chk(nak_req == 1, "R5", int'(nak_req), 1);
    send_pkt(2, 62);
    chk(rd_count == CW'(3), "R5", int'(rd_count), 3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(nak_req == 1, "R6", int'(nak_req), 1);
      chk(rd_data == RW'(pat(60, i)), "R4", int'(rd_data), int'(pat(60, i)));
      rd_stb = 1'b1;
    end
    @(negedge clk); rd_stb = 1'b0;
    chk(nak_req == 0, "R6", int'(nak_req), 0);
    drain_pkt(5, 61, "R5");
    chk(rd_avail == 0, "R5", int'(rd_avail), 0);
    clear_irq();

    // R7: clear and a commit in the same cycle leave irq set
    send_bytes(1, 70);
    rx_eop = 1'b1; irq_clr = 1'b1;
    @(negedge clk); rx_eop = 1'b0; irq_clr = 1'b0;
    chk(irq == 1, "R7", int'(irq), 1);
    clear_irq();
    chk(irq == 0, "R7", int'(irq), 0);

    // R4: final read of one slot and commit on the other in one cycle
    send_bytes(4, 71);
    for (int i = 0; i < 1; i++) begin
      @(negedge clk);
      chk(rd_data == RW'(pat(70, 0)), "R4", int'(rd_data), int'(pat(70, 0)));
      rd_stb = 1'b1; rx_eop = 1'b1;
    end
    @(negedge clk); rd_stb = 1'b0; rx_eop = 1'b0;
    chk(rd_avail == 1, "R4", int'(rd_avail), 1);
    chk(rd_count == CW'(4), "R4", int'(rd_count), 4);
    chk(irq == 1, "R7", int'(irq), 1);
    chk(nak_req == 0, "R5", int'(nak_req), 0);
    drain_pkt(4, 71, "R4");
    chk(rd_avail == 0, "R4", int'(rd_avail), 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule